// File: doc/BRIEF.md
# Partitioned Translation Buffer with Bulk Invalidation

This block is a small fully associative address translation buffer. Each slot stores a virtual page tag, a page-size code, a partition number, an address-space context, a flag that marks the mapping as a real (context-free) one, a pinned flag, a privileged flag, a physical page and a valid/occupied pair. A combinational lookup port searches all slots at once and returns the lowest matching slot index in one-hot and binary form, the composed physical page and the privilege flag.

A single command port applies one operation per clock. The operations are: fill a slot, drop the mappings that cover one page, drop everything in a context, drop every unpinned mapping of a partition, and clear the whole buffer. Every bulk operation finishes in one cycle through a parallel match over all slots. A live count of occupied slots is kept. A one-cycle stale pulse follows every accepted operation, so that the owner of any translation shortcut can drop it.

The slot count is a parameter. It must be a power of two between 2 and 64, and elaboration stops if it is not.

Top module: `ptb_part_tlb`

## Requirements
- R1: After reset no slot is valid, `occ_count_o` is 0, `stale_o` is low and every lookup misses.
- R2: Command code 1 (fill) writes all entry fields into slot `cmd_slot_i` when `cmd_slot_en_i` is 1. Otherwise it writes the lowest-numbered invalid slot, or the highest slot when all are valid. The slot becomes valid and occupied.
- R3: `occ_count_o` always equals the number of occupied slots. A fill of an unoccupied slot adds 1, and each occupied slot removed by any drop or clear subtracts 1.
- R4: Command code 2 (page drop) removes every valid slot that a lookup with the command's page, partition, context and real flag would hit, using each slot's own size mask. The pinned flag is ignored.
- R5: Command code 3 (context drop) removes every slot whose partition and context both equal the command's, pinned or not and regardless of the real flag.
- R6: Command code 4 (partition drop) removes every slot of the command's partition whose pinned flag is clear. Pinned slots stay valid.
- R7: Command code 5 (clear) makes every slot invalid and unoccupied and sets `occ_count_o` to 0.
- R8: `stale_o` is high for exactly the one cycle after the edge that accepts a command with code 1 to 5. Codes 0, 6 and 7 change no slot, do not change the count and raise no stale pulse.
- R9: A lookup hits a slot when it is valid and the partition and real flag are equal. The contexts must also be equal unless the slot is real. The page numbers must agree in every bit at or above position 3×size code, so size code k ignores the low 3k page bits.
- R10: When several slots hit, the lowest index is reported. `lk_onehot_o` has exactly that bit set, and it is zero on a miss.
- R11: On a hit, `lk_ppn_o` takes its low 3k bits from the lookup page and the remaining bits from the slot's physical page, and `lk_priv_o` is the slot's privileged flag. On a miss both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Command code (1 fill, 2 page drop, 3 context drop, 4 partition drop, 5 clear) |
| cmd_slot_en_i | input | 1 | Fill uses `cmd_slot_i` instead of the free-slot search |
| cmd_slot_i | input | IDX_W | Explicit fill slot |
| cmd_vpn_i | input | VPN_W | Virtual page for fill or page drop |
| cmd_size_i | input | SZ_W | Page-size code for fill |
| cmd_part_i | input | PART_W | Partition for fill and drops |
| cmd_ctx_i | input | CTX_W | Context for fill and drops |
| cmd_real_i | input | 1 | Real flag for fill and page drop |
| cmd_pin_i | input | 1 | Pinned flag for fill |
| cmd_priv_i | input | 1 | Privileged flag for fill |
| cmd_ppn_i | input | PPN_W | Physical page for fill |
| lk_vpn_i | input | VPN_W | Lookup virtual page |
| lk_part_i | input | PART_W | Lookup partition |
| lk_ctx_i | input | CTX_W | Lookup context |
| lk_real_i | input | 1 | Lookup real flag |
| lk_hit_o | output | 1 | Lookup found a slot |
| lk_idx_o | output | IDX_W | Index of the hitting slot |
| lk_onehot_o | output | ENTRIES | One-hot form of the hitting slot |
| lk_ppn_o | output | PPN_W | Composed physical page |
| lk_priv_o | output | 1 | Privileged flag of the hitting slot |
| occ_count_o | output | CNT_W | Number of occupied slots |
| stale_o | output | 1 | One-cycle pulse after each accepted command |

## Verification
Directed fills first pack every slot in order and then overfill. This separates the free-slot search from the explicit-slot path and from the full-buffer fallback. Each drop kind is then aimed at a mix of pinned and unpinned slots in two partitions and several contexts. This tells a page drop that honours large pages apart from one that compares exact tags, and a partition drop that spares pinned slots apart from a context drop that does not. Duplicate mappings and real mappings looked up under a foreign context check the priority and the context bypass. A long seeded random mix of all eight command codes over a narrow key space then forces frequent overlaps, drops of empty keys and ignored codes. After every step the lookups and the occupied count are compared with a bench model.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
   typedef enum logic [2:0] {
      PTB_NOP        = 3'd0,
      PTB_FILL       = 3'd1,
      PTB_DROP_PAGE  = 3'd2,
      PTB_DROP_CTX   = 3'd3,
      PTB_DROP_PART  = 3'd4,
      PTB_CLEAR      = 3'd5
   } ptb_op_e;

   function automatic logic ptb_op_accepted(input logic [2:0] code);
      return (code >= 3'd1) && (code <= 3'd5);
   endfunction
endpackage

// File: rtl/ptb_page_match.sv
module ptb_page_match #(
   parameter int VPN_W   = 20,
   parameter int CTX_W   = 13,
   parameter int PART_W  = 8,
   parameter int SZ_W    = 2,
   parameter int SZ_STEP = 3
) (
   input  logic              e_valid,
   input  logic [VPN_W-1:0]  e_vpn,
   input  logic [SZ_W-1:0]   e_size,
   input  logic [PART_W-1:0] e_part,
   input  logic [CTX_W-1:0]  e_ctx,
   input  logic              e_real,
   input  logic [VPN_W-1:0]  q_vpn,
   input  logic [PART_W-1:0] q_part,
   input  logic [CTX_W-1:0]  q_ctx,
   input  logic              q_real,
   output logic              hit
);
   logic [VPN_W-1:0] care;
   int               low_bits;

   always_comb begin
      low_bits = int'(e_size) * SZ_STEP;
      for (int b = 0; b < VPN_W; b++) care[b] = (b >= low_bits);
   end

   assign hit = e_valid && (e_part == q_part) && (e_real == q_real) &&
                (e_real || (e_ctx == q_ctx)) &&
                (((e_vpn ^ q_vpn) & care) == '0);
endmodule

// File: rtl/ptb_first_set.sv
module ptb_first_set #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx,
   output logic [N-1:0]     onehot
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end

   assign found  = |vec;
   assign onehot = vec & (~vec + N'(1));
endmodule

// File: rtl/ptb_part_tlb.sv
module ptb_part_tlb
   import ptb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int CTX_W   = 13,
   parameter int PART_W  = 8,
   parameter int SZ_W    = 2,
   parameter int SZ_STEP = 3,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid_i,
   input  logic [2:0]         cmd_op_i,
   input  logic               cmd_slot_en_i,
   input  logic [IDX_W-1:0]   cmd_slot_i,
   input  logic [VPN_W-1:0]   cmd_vpn_i,
   input  logic [SZ_W-1:0]    cmd_size_i,
   input  logic [PART_W-1:0]  cmd_part_i,
   input  logic [CTX_W-1:0]   cmd_ctx_i,
   input  logic               cmd_real_i,
   input  logic               cmd_pin_i,
   input  logic               cmd_priv_i,
   input  logic [PPN_W-1:0]   cmd_ppn_i,
   input  logic [VPN_W-1:0]   lk_vpn_i,
   input  logic [PART_W-1:0]  lk_part_i,
   input  logic [CTX_W-1:0]   lk_ctx_i,
   input  logic               lk_real_i,
   output logic               lk_hit_o,
   output logic [IDX_W-1:0]   lk_idx_o,
   output logic [ENTRIES-1:0] lk_onehot_o,
   output logic [PPN_W-1:0]   lk_ppn_o,
   output logic               lk_priv_o,
   output logic [CNT_W-1:0]   occ_count_o,
   output logic               stale_o
);
   localparam int MAX_LOW = ((1 << SZ_W) - 1) * SZ_STEP;

   if (ENTRIES < 2 || ENTRIES > 64 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two from 2 to 64");
   end
   if (MAX_LOW > VPN_W || MAX_LOW > PPN_W) begin : g_bad_size
      $error("largest page size exceeds page number width");
   end

   // slot storage
   logic [ENTRIES-1:0] valid_q, used_q, pin_q, priv_q, real_q;
   logic [VPN_W-1:0]   vpn_q  [ENTRIES];
   logic [PPN_W-1:0]   ppn_q  [ENTRIES];
   logic [SZ_W-1:0]    size_q [ENTRIES];
   logic [PART_W-1:0]  part_q [ENTRIES];
   logic [CTX_W-1:0]   ctx_q  [ENTRIES];
   logic [CNT_W-1:0]   cnt_q;
   logic               stale_q;

   ptb_op_e            op;
   logic [ENTRIES-1:0] lk_hits, pg_hits, ctx_hits, prt_hits, kill;
   logic [ENTRIES-1:0] free_onehot;
   logic               free_found;
   logic [IDX_W-1:0]   free_idx, fill_idx;
   logic [CNT_W-1:0]   kill_cnt;

   assign op = ptb_op_e'(cmd_op_i);

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      ptb_page_match #(
         .VPN_W(VPN_W), .CTX_W(CTX_W), .PART_W(PART_W), .SZ_W(SZ_W), .SZ_STEP(SZ_STEP)
      ) i_lk_match (
         .e_valid(valid_q[i]), .e_vpn(vpn_q[i]), .e_size(size_q[i]),
         .e_part(part_q[i]), .e_ctx(ctx_q[i]), .e_real(real_q[i]),
         .q_vpn(lk_vpn_i), .q_part(lk_part_i), .q_ctx(lk_ctx_i), .q_real(lk_real_i),
         .hit(lk_hits[i])
      );
      ptb_page_match #(
         .VPN_W(VPN_W), .CTX_W(CTX_W), .PART_W(PART_W), .SZ_W(SZ_W), .SZ_STEP(SZ_STEP)
      ) i_pg_match (
         .e_valid(valid_q[i]), .e_vpn(vpn_q[i]), .e_size(size_q[i]),
         .e_part(part_q[i]), .e_ctx(ctx_q[i]), .e_real(real_q[i]),
         .q_vpn(cmd_vpn_i), .q_part(cmd_part_i), .q_ctx(cmd_ctx_i), .q_real(cmd_real_i),
         .hit(pg_hits[i])
      );
      assign ctx_hits[i] = (part_q[i] == cmd_part_i) && (ctx_q[i] == cmd_ctx_i);
      assign prt_hits[i] = (part_q[i] == cmd_part_i) && !pin_q[i];
   end

   // which slots a drop removes
   always_comb begin
      unique case (op)
         PTB_DROP_PAGE: kill = pg_hits;
         PTB_DROP_CTX:  kill = ctx_hits;
         PTB_DROP_PART: kill = prt_hits;
         PTB_CLEAR:     kill = '1;
         default:       kill = '0;
      endcase
   end

   always_comb begin
      kill_cnt = '0;
      for (int i = 0; i < ENTRIES; i++) kill_cnt = kill_cnt + CNT_W'(kill[i] & used_q[i]);
   end

   ptb_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) i_free (
      .vec(~valid_q), .found(free_found), .idx(free_idx), .onehot(free_onehot)
   );

   assign fill_idx = cmd_slot_en_i ? cmd_slot_i :
                     (free_found ? free_idx : IDX_W'(ENTRIES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         used_q  <= '0;
         pin_q   <= '0;
         priv_q  <= '0;
         real_q  <= '0;
         cnt_q   <= '0;
         stale_q <= 1'b0;
         for (int i = 0; i < ENTRIES; i++) begin
            vpn_q[i]  <= '0;
            ppn_q[i]  <= '0;
            size_q[i] <= '0;
            part_q[i] <= '0;
            ctx_q[i]  <= '0;
         end
      end else begin
         stale_q <= cmd_valid_i && ptb_op_accepted(cmd_op_i);
         if (cmd_valid_i) begin
            if (op == PTB_FILL) begin
               valid_q[fill_idx] <= 1'b1;
               used_q[fill_idx]  <= 1'b1;
               pin_q[fill_idx]   <= cmd_pin_i;
               priv_q[fill_idx]  <= cmd_priv_i;
               real_q[fill_idx]  <= cmd_real_i;
               vpn_q[fill_idx]   <= cmd_vpn_i;
               ppn_q[fill_idx]   <= cmd_ppn_i;
               size_q[fill_idx]  <= cmd_size_i;
               part_q[fill_idx]  <= cmd_part_i;
               ctx_q[fill_idx]   <= cmd_ctx_i;
               cnt_q <= cnt_q + CNT_W'(!used_q[fill_idx]);
            end else begin
               valid_q <= valid_q & ~kill;
               used_q  <= used_q & ~kill;
               cnt_q   <= cnt_q - kill_cnt;
            end
         end
      end
   end

   // lookup result
   logic             lk_found;
   logic [PPN_W-1:0] sel_ppn;
   int               sel_low;

   ptb_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) i_lk_pick (
      .vec(lk_hits), .found(lk_found), .idx(lk_idx_o), .onehot(lk_onehot_o)
   );

   always_comb begin
      sel_ppn = ppn_q[lk_idx_o];
      sel_low = int'(size_q[lk_idx_o]) * SZ_STEP;
      lk_ppn_o = '0;
      if (lk_found) begin
         for (int b = 0; b < PPN_W; b++) begin
            if (b < sel_low && b < VPN_W) lk_ppn_o[b] = lk_vpn_i[b];
            else                          lk_ppn_o[b] = sel_ppn[b];
         end
      end
   end

   assign lk_hit_o    = lk_found;
   assign lk_priv_o   = lk_found && priv_q[lk_idx_o];
   assign occ_count_o = cnt_q;
   assign stale_o     = stale_q;
endmodule

// File: rtl/ptb_part_tlb_chk.sv
module ptb_part_tlb_chk #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4,
   parameter int CNT_W   = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid_i,
   input logic [2:0]         cmd_op_i,
   input logic [ENTRIES-1:0] valid_q,
   input logic [ENTRIES-1:0] used_q,
   input logic [CNT_W-1:0]   occ_count_o,
   input logic               stale_o,
   input logic               lk_hit_o,
   input logic [IDX_W-1:0]   lk_idx_o,
   input logic [ENTRIES-1:0] lk_onehot_o
);
   logic accepted;
   assign accepted = cmd_valid_i && (cmd_op_i >= 3'd1) && (cmd_op_i <= 3'd5);

   // R3
   count_tracks_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ_count_o == CNT_W'($countones(used_q)));

   // R3
   used_within_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (used_q & ~valid_q) == '0);

   // R10
   onehot_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_onehot_o) && (lk_hit_o == (lk_onehot_o != '0)));

   // R10
   onehot_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit_o |-> lk_onehot_o[lk_idx_o]);

   // R8
   stale_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accepted |=> stale_o);

   // R8
   stale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !accepted |=> !stale_o);

   // R8
   ignored_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && !accepted) |=> ($stable(valid_q) && $stable(occ_count_o)));

   // R7
   clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && cmd_op_i == 3'd5) |=> (valid_q == '0 && occ_count_o == '0));
endmodule

bind ptb_part_tlb ptb_part_tlb_chk #(
   .ENTRIES(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)
) i_chk (.*);

// File: tb/test_ptb_part_tlb.sv
`timescale 1ns/1ps
module test_ptb_part_tlb;
   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid_i = 1'b0;
   logic [2:0]  cmd_op_i = '0;
   logic        cmd_slot_en_i = 1'b0;
   logic [3:0]  cmd_slot_i = '0;
   logic [19:0] cmd_vpn_i = '0;
   logic [1:0]  cmd_size_i = '0;
   logic [7:0]  cmd_part_i = '0;
   logic [12:0] cmd_ctx_i = '0;
   logic        cmd_real_i = 1'b0, cmd_pin_i = 1'b0, cmd_priv_i = 1'b0;
   logic [19:0] cmd_ppn_i = '0;
   logic [19:0] lk_vpn_i = '0;
   logic [7:0]  lk_part_i = '0;
   logic [12:0] lk_ctx_i = '0;
   logic        lk_real_i = 1'b0;
   logic        lk_hit_o, lk_priv_o, stale_o;
   logic [3:0]  lk_idx_o;
   logic [N-1:0] lk_onehot_o;
   logic [19:0] lk_ppn_o;
   logic [4:0]  occ_count_o;

   ptb_part_tlb i_ptb_part_tlb (.*);

   always #2.5 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // bench model
   bit       m_valid [N];
   bit       m_used  [N];
   bit       m_pin   [N];
   bit       m_priv  [N];
   bit       m_real  [N];
   int       m_vpn   [N];
   int       m_ppn   [N];
   int       m_size  [N];
   int       m_part  [N];
   int       m_ctx   [N];
   int       m_cnt = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit m_hit(int i, int vpn, int part, int ctx, bit rl);
      if (!m_valid[i] || m_part[i] != part || m_real[i] != rl) return 0;
      if (!rl && m_ctx[i] != ctx) return 0;
      return ((m_vpn[i] ^ vpn) >> (3 * m_size[i])) == 0;
   endfunction

   function automatic int m_lookup(int vpn, int part, int ctx, bit rl);
      for (int i = 0; i < N; i++) if (m_hit(i, vpn, part, ctx, rl)) return i;
      return -1;
   endfunction

   function automatic int m_ppn_of(int i, int vpn);
      int mask;
      mask = (1 << (3 * m_size[i])) - 1;
      return (m_ppn[i] & ~mask) | (vpn & mask);
   endfunction

   task automatic m_drop(int i);
      if (m_used[i]) m_cnt--;
      m_valid[i] = 0;
      m_used[i] = 0;
   endtask

   task automatic m_apply(int op, bit sen, int slot, int vpn, int sz, int part,
                          int ctx, bit rl, bit pin, bit pv, int ppn);
      int t;
      bit hits [N];
      case (op)
         1: begin
            if (sen) t = slot;
            else begin
               t = N - 1;
               for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) t = i;
            end
            if (!m_used[t]) m_cnt++;
            m_valid[t] = 1; m_used[t] = 1; m_pin[t] = pin; m_priv[t] = pv;
            m_real[t] = rl; m_vpn[t] = vpn; m_ppn[t] = ppn; m_size[t] = sz;
            m_part[t] = part; m_ctx[t] = ctx;
         end
         2: begin
            for (int i = 0; i < N; i++) hits[i] = m_hit(i, vpn, part, ctx, rl);
            for (int i = 0; i < N; i++) if (hits[i]) m_drop(i);
         end
         3: for (int i = 0; i < N; i++)
               if (m_part[i] == part && m_ctx[i] == ctx) m_drop(i);
         4: for (int i = 0; i < N; i++)
               if (m_part[i] == part && !m_pin[i]) m_drop(i);
         5: for (int i = 0; i < N; i++) m_drop(i);
         default: ;
      endcase
   endtask

   task automatic do_op(input string req, input int op, input bit sen, input int slot,
                        input int vpn, input int sz, input int part, input int ctx,
                        input bit rl, input bit pin, input bit pv, input int ppn);
      @(negedge clk);
      cmd_valid_i = 1'b1; cmd_op_i = op[2:0]; cmd_slot_en_i = sen; cmd_slot_i = slot[3:0];
      cmd_vpn_i = vpn[19:0]; cmd_size_i = sz[1:0]; cmd_part_i = part[7:0];
      cmd_ctx_i = ctx[12:0]; cmd_real_i = rl; cmd_pin_i = pin; cmd_priv_i = pv;
      cmd_ppn_i = ppn[19:0];
      @(posedge clk);
      #1;
      cmd_valid_i = 1'b0;
      m_apply(op, sen, slot, vpn, sz, part, ctx, rl, pin, pv, ppn);
      // R8 pulse after accepted codes only
      check(stale_o == (op >= 1 && op <= 5), "R8", "stale pulse", stale_o, (op >= 1 && op <= 5));
      // R3 count
      check(occ_count_o == m_cnt[4:0], "R3", "occupied count", occ_count_o, m_cnt);
   endtask

   task automatic lk_chk(input string req, input int vpn, input int part,
                         input int ctx, input bit rl);
      int e;
      @(negedge clk);
      lk_vpn_i = vpn[19:0]; lk_part_i = part[7:0]; lk_ctx_i = ctx[12:0]; lk_real_i = rl;
      #1;
      e = m_lookup(vpn, part, ctx, rl);
      check(lk_hit_o == (e >= 0), req, "hit", lk_hit_o, (e >= 0));
      if (e >= 0) begin
         check(lk_idx_o == e[3:0], req, "hit index", lk_idx_o, e);
         check(lk_onehot_o == (N'(1) << e), "R10", "one-hot", lk_onehot_o, N'(1) << e);
         check(lk_ppn_o == m_ppn_of(e, vpn), "R11", "physical page", lk_ppn_o, m_ppn_of(e, vpn));
         check(lk_priv_o == m_priv[e], "R11", "priv", lk_priv_o, m_priv[e]);
      end else begin
         check(lk_onehot_o == '0 && lk_ppn_o == '0 && !lk_priv_o, "R11", "miss outputs",
               {lk_onehot_o, lk_ppn_o}, 0);
      end
   endtask

   task automatic lk_all(input string req);
      for (int i = 0; i < N; i++)
         if (m_valid[i]) lk_chk(req, m_vpn[i], m_part[i], m_ctx[i], m_real[i]);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < N; i++) begin
         m_valid[i] = 0; m_used[i] = 0; m_pin[i] = 0; m_priv[i] = 0; m_real[i] = 0;
         m_vpn[i] = 0; m_ppn[i] = 0; m_size[i] = 0; m_part[i] = 0; m_ctx[i] = 0;
      end
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check(occ_count_o == 0, "R1", "count at reset", occ_count_o, 0);
      check(stale_o == 0, "R1", "stale at reset", stale_o, 0);
      rst_n = 1'b1;
      lk_chk("R1", 0, 0, 0, 0);
      lk_chk("R1", 20'h12, 1, 1, 1);

      // R2 pack all slots in order by free-slot search
      for (int i = 0; i < N; i++)
         do_op("R2", 1, 0, 0, 20'h400 + i * 8, 0, 1, i % 3, 0, i < 2, i[0], 20'h100 + i);
      lk_all("R2");
      // R2 full buffer falls back to the highest slot
      do_op("R2", 1, 0, 0, 20'h777, 1, 1, 2, 0, 0, 1, 20'h5550);
      lk_chk("R2", 20'h777, 1, 2, 0);
      lk_chk("R2", 20'h400 + 15 * 8, 1, 0, 0);
      // R2 explicit slot
      do_op("R2", 1, 1, 5, 20'h888, 0, 1, 1, 0, 0, 0, 20'h2222);
      lk_chk("R2", 20'h888, 1, 1, 0);
      // R9 large page: size 2 ignores low 6 bits
      do_op("R9", 1, 1, 3, 20'h1000, 2, 1, 0, 0, 0, 1, 20'hABCC0);
      lk_chk("R9", 20'h1025, 1, 0, 0);
      lk_chk("R9", 20'h1040, 1, 0, 0);
      // R4 page drop inside the large page
      do_op("R4", 2, 0, 0, 20'h1025, 0, 1, 0, 0, 0, 0, 0);
      lk_chk("R4", 20'h1000, 1, 0, 0);
      // R4 page drop hits pinned slot 0
      do_op("R4", 2, 0, 0, 20'h400, 0, 1, 0, 0, 0, 0, 0);
      lk_chk("R4", 20'h400, 1, 0, 0);
      // R5 context drop, pinned slot 1 has ctx 1
      do_op("R5", 3, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
      lk_all("R5");
      lk_chk("R5", 20'h408, 1, 1, 0);
      // R6 partition drop spares pinned
      do_op("R6", 1, 1, 0, 20'h400, 0, 1, 0, 0, 1, 0, 20'h100);
      do_op("R6", 1, 1, 9, 20'h900, 0, 2, 0, 0, 0, 0, 20'h900);
      do_op("R6", 4, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      lk_chk("R6", 20'h400, 1, 0, 0);
      lk_chk("R6", 20'h900, 2, 0, 0);
      lk_chk("R6", 20'h410, 1, 2, 0);
      // R9 real mapping ignores context
      do_op("R9", 1, 0, 0, 20'h333, 0, 2, 7, 1, 0, 1, 20'h3333);
      lk_chk("R9", 20'h333, 2, 0, 1);
      lk_chk("R9", 20'h333, 2, 7, 0);
      // R10 duplicates: lowest index wins
      do_op("R10", 1, 1, 12, 20'h444, 0, 2, 3, 0, 0, 0, 20'h4C);
      do_op("R10", 1, 1, 7, 20'h444, 0, 2, 3, 0, 0, 1, 20'h47);
      lk_chk("R10", 20'h444, 2, 3, 0);
      // R8 ignored codes
      do_op("R8", 6, 0, 0, 0, 0, 2, 3, 0, 0, 0, 0);
      do_op("R8", 0, 0, 0, 0, 0, 2, 3, 0, 0, 0, 0);
      do_op("R8", 7, 0, 0, 0, 0, 2, 0, 0, 0, 0, 0);
      lk_all("R8");
      // R8 pulse lasts one cycle
      @(posedge clk); #1;
      check(stale_o == 0, "R8", "stale after idle", stale_o, 0);
      // R7 clear
      do_op("R7", 5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      check(occ_count_o == 0, "R7", "count after clear", occ_count_o, 0);
      lk_chk("R7", 20'h400, 1, 0, 0);
      lk_chk("R7", 20'h333, 2, 0, 1);

      // random mix
      for (int k = 0; k < 3000; k++) begin
         int op, vpn, part, ctx;
         op = ($urandom_range(0, 9) < 5) ? 1 : $urandom_range(0, 7);
         if (op == 5 && $urandom_range(0, 3) != 0) op = 2;
         vpn = $urandom_range(0, 255);
         part = $urandom_range(0, 1);
         ctx = $urandom_range(0, 2);
         do_op("R3", op, $urandom_range(0, 3) == 0, $urandom_range(0, N - 1), vpn,
               $urandom_range(0, 3), part, ctx, $urandom_range(0, 3) == 0,
               $urandom_range(0, 2) == 0, $urandom_range(0, 1), $urandom_range(0, 20'hFFFFF));
         lk_chk("R9", $urandom_range(0, 255), $urandom_range(0, 1), $urandom_range(0, 2),
                $urandom_range(0, 3) == 0);
         lk_chk("R4", vpn, part, ctx, 0);
      end
      lk_all("R9");
      finish_run();
   end
endmodule